// File: doc/BRIEF.md
# Root Port Error Collector

This block is the final stage of error reporting in a root port. It accepts error messages that have already passed the bridge and device enable checks. Each message carries a severity (correctable, non-fatal or fatal) and a 16-bit requester source ID. The block keeps a root error status word and two captured source IDs, one for correctable errors and one for uncorrectable errors. It raises the root error interrupt according to a 3-bit root error command word.

Software reaches the block through plain write ports. One port writes the command word. One port clears status bits by writing a one to each bit to be cleared. A third port sets the interrupt vector number. This vector cannot be changed through the status clear path. A mode input selects how the interrupt is delivered. In legacy mode it is a level line. In message mode it is a one-cycle pulse that carries the vector on a side output.

Top module: `root_err_collector`

## Requirements
- R1: A message with severity code 1 (correctable) handles the source ID as follows. If status bit 0 (correctable received) is already set, it sets status bit 1 (multiple correctable). Otherwise it copies the source ID into `cor_src`. In both cases it then sets bit 0.
- R2: A message with severity code 2 (non-fatal) or 3 (fatal) handles the source ID as follows. If status bit 2 (uncorrectable received) is already set, it sets status bit 3 (multiple uncorrectable). Otherwise it copies the source ID into `unc_src`. It then sets bit 2. A non-fatal message also sets status bit 5.
- R3: A fatal message always sets status bit 6. It sets status bit 4 (first fatal) only when bit 2 was clear before the message.
- R4: A write on the clear port clears every status bit whose mask bit is one. When a clear and a message arrive in the same cycle, the clear acts first and the message's bits are then set on top of it. All results appear on the outputs one cycle after the inputs are sampled.
- R5: The enabled condition is the reduction OR of a 3-bit vector ANDed with the command word. The vector holds status bit 0 in position 0, status bit 5 in position 1 and status bit 6 in position 2. Command bit 0 enables correctable errors, bit 1 non-fatal errors and bit 2 fatal errors.
- R6: In message mode (`msg_mode`=1), `irq_pulse` is high for exactly one cycle when a message or a command write turns the enabled condition from false to true. At that cycle `irq_vec` shows the vector that was held when the trigger was sampled. No pulse occurs otherwise.
- R7: In legacy mode, a command write sets `irq_level` to the new enabled condition. A message that turns the condition from false to true raises `irq_level`. Status clears alone leave the level unchanged. `irq_pulse` never fires, and `irq_level` is low in message mode.
- R8: The vector changes only through the vector port. Status clears leave it unchanged.
- R9: Reset clears the command word, the status word, both source fields, the vector and both interrupt outputs.
- R10: A message with severity code 0 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | An error message is present this cycle |
| msg_sev | input | 2 | Severity: 0 none, 1 correctable, 2 non-fatal, 3 fatal |
| msg_src | input | SRC_W | Source ID of the message |
| cmd_we | input | 1 | Write the command word |
| cmd_wdata | input | 3 | New command word |
| clr_we | input | 1 | Write-one-to-clear strobe for the status word |
| clr_mask | input | 7 | Status bits to clear |
| vec_we | input | 1 | Write the interrupt vector |
| vec_wdata | input | VEC_W | New interrupt vector |
| msg_mode | input | 1 | 1 selects message interrupts, 0 selects the legacy level |
| root_cmd | output | 3 | Command word |
| root_stat | output | 7 | Status word |
| cor_src | output | SRC_W | Captured correctable source ID |
| unc_src | output | SRC_W | Captured uncorrectable source ID |
| vec | output | VEC_W | Interrupt vector number |
| irq_level | output | 1 | Legacy interrupt line |
| irq_pulse | output | 1 | One-cycle message interrupt |
| irq_vec | output | VEC_W | Vector attached to irq_pulse |

## Verification
The bench uses the default widths, a 16-bit source ID and a 5-bit vector. The command word has only three bits and there are only four severity codes, so every command value is swept in both interrupt modes against every ordered pair of severity codes. Each run ends with a cycle where a clear and a message collide. This covers every first and repeat capture ordering, every first-fatal outcome and every rising or non-rising edge of the enabled condition. A final directed pass checks that the vector survives status clears and that a pulse carries the vector held when the trigger was sampled.

// File: rtl/root_err_collector.sv
module root_err_collector #(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             msg_valid,
  input  logic [1:0]       msg_sev,
  input  logic [SRC_W-1:0] msg_src,
  input  logic             cmd_we,
  input  logic [2:0]       cmd_wdata,
  input  logic             clr_we,
  input  logic [6:0]       clr_mask,
  input  logic             vec_we,
  input  logic [VEC_W-1:0] vec_wdata,
  input  logic             msg_mode,
  output logic [2:0]       root_cmd,
  output logic [6:0]       root_stat,
  output logic [SRC_W-1:0] cor_src,
  output logic [SRC_W-1:0] unc_src,
  output logic [VEC_W-1:0] vec,
  output logic             irq_level,
  output logic             irq_pulse,
  output logic [VEC_W-1:0] irq_vec
);
  localparam int B_COR = 0, B_MCOR = 1, B_UNC = 2, B_MUNC = 3, B_FFAT = 4, B_NFAT = 5, B_FAT = 6;

  logic [6:0]       stat_c, stat_n;
  logic [SRC_W-1:0] cor_n, unc_n;
  logic [2:0]       cmd_n;
  logic             cond_pre, cond_nxt, rise;

  function automatic logic [2:0] rcv_map(input logic [6:0] s);
    return {s[B_FAT], s[B_NFAT], s[B_COR]};
  endfunction

  assign stat_c = clr_we ? (root_stat & ~clr_mask) : root_stat;
  assign cmd_n  = cmd_we ? cmd_wdata : root_cmd;

  always_comb begin
    stat_n = stat_c;
    cor_n  = cor_src;
    unc_n  = unc_src;
    if (msg_valid && msg_sev == 2'd1) begin
      if (stat_c[B_COR]) stat_n[B_MCOR] = 1'b1;
      else               cor_n = msg_src;
      stat_n[B_COR] = 1'b1;
    end
    if (msg_valid && msg_sev[1]) begin
      if (stat_c[B_UNC]) stat_n[B_MUNC] = 1'b1;
      else               unc_n = msg_src;
      stat_n[B_UNC] = 1'b1;
      if (msg_sev[0]) begin
        if (!stat_c[B_UNC]) stat_n[B_FFAT] = 1'b1;
        stat_n[B_FAT] = 1'b1;
      end else begin
        stat_n[B_NFAT] = 1'b1;
      end
    end
  end

  assign cond_pre = |(rcv_map(stat_c) & root_cmd);
  assign cond_nxt = |(rcv_map(stat_n) & cmd_n);
  assign rise     = (msg_valid || cmd_we) && cond_nxt && !cond_pre;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      root_cmd  <= '0;
      root_stat <= '0;
      cor_src   <= '0;
      unc_src   <= '0;
      vec       <= '0;
      irq_level <= 1'b0;
      irq_pulse <= 1'b0;
      irq_vec   <= '0;
    end else begin
      root_cmd  <= cmd_n;
      root_stat <= stat_n;
      cor_src   <= cor_n;
      unc_src   <= unc_n;
      if (vec_we) vec <= vec_wdata;
      irq_pulse <= msg_mode && rise;
      if (msg_mode && rise) irq_vec <= vec;
      if (msg_mode)    irq_level <= 1'b0;
      else if (cmd_we) irq_level <= cond_nxt;
      else if (rise)   irq_level <= 1'b1;
    end
  end
endmodule

// File: rtl/root_err_collector_chk.sv
module root_err_collector_chk #(
  parameter int SRC_W = 16,
  parameter int VEC_W = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic [1:0]       msg_sev,
  input logic             cmd_we,
  input logic             clr_we,
  input logic [6:0]       clr_mask,
  input logic             vec_we,
  input logic             msg_mode,
  input logic [6:0]       root_stat,
  input logic [SRC_W-1:0] cor_src,
  input logic [VEC_W-1:0] vec,
  input logic             irq_level,
  input logic             irq_pulse
);
  a_r1_cor_sets_rcv: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd1) |=> root_stat[0]);
  a_r1_repeat_cor_multi: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd1 && root_stat[0] && !(clr_we && clr_mask[0])) |=> root_stat[1]);
  a_r1_cor_src_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_valid && msg_sev == 2'd1) |=> $stable(cor_src));
  a_r3_first_fatal: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && msg_sev == 2'd3 && !root_stat[2]) |=> (root_stat[4] && root_stat[6]));
  a_r6_pulse_needs_trigger: assert property (@(posedge clk) disable iff (!rst_n)
    (!msg_valid && !cmd_we) |=> !irq_pulse);
  a_r7_no_pulse_legacy: assert property (@(posedge clk) disable iff (!rst_n)
    !msg_mode |=> !irq_pulse);
  a_r7_level_low_msg_mode: assert property (@(posedge clk) disable iff (!rst_n)
    msg_mode |=> !irq_level);
  a_r8_vec_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_we |=> $stable(vec));
endmodule

bind root_err_collector root_err_collector_chk #(.SRC_W(SRC_W), .VEC_W(VEC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_sev(msg_sev), .cmd_we(cmd_we),
  .clr_we(clr_we), .clr_mask(clr_mask), .vec_we(vec_we), .msg_mode(msg_mode),
  .root_stat(root_stat), .cor_src(cor_src), .vec(vec), .irq_level(irq_level),
  .irq_pulse(irq_pulse)
);

// File: tb/sim_root_err_collector.sv
module sim_root_err_collector;
  localparam int SRC_W = 16, VEC_W = 5;

  logic clk = 1'b0, rst_n = 1'b0;
  logic msg_valid = 1'b0, cmd_we = 1'b0, clr_we = 1'b0, vec_we = 1'b0, msg_mode = 1'b0;
  logic [1:0] msg_sev = '0;
  logic [SRC_W-1:0] msg_src = '0;
  logic [2:0] cmd_wdata = '0;
  logic [6:0] clr_mask = '0;
  logic [VEC_W-1:0] vec_wdata = '0;
  logic [2:0] root_cmd;
  logic [6:0] root_stat;
  logic [SRC_W-1:0] cor_src, unc_src;
  logic [VEC_W-1:0] vec, irq_vec;
  logic irq_level, irq_pulse;

  int n_chk = 0, n_bad = 0;
  logic [6:0] m_stat = '0;
  logic [2:0] m_cmd = '0;
  logic [SRC_W-1:0] m_cor = '0, m_unc = '0;
  logic [VEC_W-1:0] m_vec = '0, m_ivec = '0;
  logic m_lvl = 1'b0, m_pulse = 1'b0;

  always #10 clk = ~clk;

  root_err_collector #(.SRC_W(SRC_W), .VEC_W(VEC_W)) u0 (.*);

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: run hung, actual running expected done");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [2:0] rmap(input logic [6:0] s);
    return {s[6], s[5], s[0]};
  endfunction

  task automatic check_all(input string req);
    chk(req, "root_stat", 32'(root_stat), 32'(m_stat));
    chk(req, "root_cmd", 32'(root_cmd), 32'(m_cmd));
    chk(req, "cor_src", 32'(cor_src), 32'(m_cor));
    chk(req, "unc_src", 32'(unc_src), 32'(m_unc));
    chk(req, "vec", 32'(vec), 32'(m_vec));
    chk(req, "irq_level", 32'(irq_level), 32'(m_lvl));
    chk(req, "irq_pulse", 32'(irq_pulse), 32'(m_pulse));
    if (m_pulse) chk(req, "irq_vec", 32'(irq_vec), 32'(m_ivec));
  endtask

  // one cycle: drive at negedge, predict, check at next negedge
  task automatic step(input string req, input logic mv, input logic [1:0] sv, input logic [SRC_W-1:0] src,
                      input logic cw, input logic [2:0] cd, input logic cl, input logic [6:0] cm,
                      input logic vw, input logic [VEC_W-1:0] vd);
    logic [6:0] sc, s;
    logic [2:0] cn;
    logic pre, nxt, rs;
    msg_valid = mv; msg_sev = sv; msg_src = src; cmd_we = cw; cmd_wdata = cd;
    clr_we = cl; clr_mask = cm; vec_we = vw; vec_wdata = vd;
    sc = cl ? (m_stat & ~cm) : m_stat;
    s = sc;
    if (mv && sv == 2'd1) begin
      if (sc[0]) s[1] = 1'b1; else m_cor = src;
      s[0] = 1'b1;
    end
    if (mv && sv >= 2'd2) begin
      if (sc[2]) s[3] = 1'b1; else m_unc = src;
      s[2] = 1'b1;
      if (sv == 2'd3) begin
        if (!sc[2]) s[4] = 1'b1;
        s[6] = 1'b1;
      end else s[5] = 1'b1;
    end
    cn = cw ? cd : m_cmd;
    pre = |(rmap(sc) & m_cmd);
    nxt = |(rmap(s) & cn);
    rs = (mv || cw) && nxt && !pre;
    m_pulse = msg_mode && rs;
    if (m_pulse) m_ivec = m_vec;
    if (msg_mode) m_lvl = 1'b0;
    else if (cw) m_lvl = nxt;
    else if (rs) m_lvl = 1'b1;
    m_stat = s; m_cmd = cn;
    if (vw) m_vec = vd;
    @(posedge clk);
    @(negedge clk);
    msg_valid = 0; cmd_we = 0; clr_we = 0; vec_we = 0;
    check_all(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check_all("R9");
    rst_n = 1'b1;
    // R1 R2 R3 R4 R5 R6 R7 R10: sweep modes, commands, ordered severity pairs
    for (int md = 0; md < 2; md++) begin
      msg_mode = md[0];
      for (int c = 0; c < 8; c++) begin
        for (int s1 = 0; s1 < 4; s1++) begin
          for (int s2 = 0; s2 < 4; s2++) begin
            step("R4", 0, 0, 0, 1, 3'd0, 1, 7'h7f, 0, 0);
            step("R5", 0, 0, 0, 1, 3'(c), 0, 0, 1, 5'(c * 4 + s1));
            step("R1", 1, 2'(s1), 16'(16'h1000 + c * 16 + s1), 0, 0, 0, 0, 0, 0);
            step("R2", 1, 2'(s2), 16'(16'h2000 + s1 * 4 + s2), 0, 0, 0, 0, 0, 0);
            step("R3", 1, 2'(s1), 16'hbeef, 0, 0, 1, 7'(7'h55 >> s2), 0, 0);
            step("R6", 0, 0, 0, 1, 3'(~c), 0, 0, 0, 0);
          end
        end
      end
    end
    // R8: vector survives clears; R10: code 0 ignored
    msg_mode = 1'b1;
    step("R8", 0, 0, 0, 1, 3'd7, 1, 7'h7f, 1, 5'd19);
    step("R8", 0, 0, 0, 0, 0, 1, 7'h7f, 0, 0);
    step("R10", 1, 2'd0, 16'h1234, 0, 0, 0, 0, 0, 0);
    step("R6", 1, 2'd3, 16'h0a0a, 0, 0, 0, 0, 1, 5'd7);
    step("R7", 0, 0, 0, 1, 3'd0, 0, 0, 0, 0);
    rst_n = 1'b0;
    @(posedge clk); @(negedge clk);
    m_stat = '0; m_cmd = '0; m_cor = '0; m_unc = '0; m_vec = '0; m_lvl = 0; m_pulse = 0;
    check_all("R9");
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule